// File: doc/BRIEF.md
# Card Clock Prescaler with Divider Calculator

This block produces the card-side clock of an SD/MMC host from a faster system clock. A configuration write loads an 8-bit divider value N and an enable bit. While the enable bit is set, the card clock runs at the system clock divided by 2*(N+1), with equal high and low phases. While the enable bit is clear, the card clock is held low. When N is changed on a running clock, the new value is picked up only at the next output transition, so the phase that is in progress keeps its length and no short pulse appears.

Next to the generator there is a sequential calculator that gives software the divider to program. It takes the input clock frequency and a requested card frequency, both in Hz, and clamps the request to a fixed window. It then finds a first estimate by integer division. The estimate is raised by one when it would run faster than the request, and the result is saturated to the 8-bit range. The division runs as a restoring divider that produces one quotient bit per cycle. A start pulse launches a calculation, and a done level flags the result. The usual software sequence is to write zero to stop the clock, run the calculator, and then write the result together with the enable bit.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, card_clk is low, calc_done is low and calc_div is 0.
- R2: A write with cfg_we high takes cfg_wdata[8] as the enable bit and cfg_wdata[7:0] as N. If the clock was stopped, the first rising edge of card_clk comes N+1 clock edges after the write edge. After that, card_clk stays high for N+1 cycles and low for N+1 cycles.
- R3: A write that clears the enable bit makes card_clk low from the second clock edge after the write edge. card_clk then stays low for as long as the bit remains clear.
- R4: A new N written while the clock runs does not change the phase in progress. The new N sets the length of every phase from the next card_clk transition on.
- R5: Before the divider is computed, the calculator clamps the requested frequency to the range 200000 Hz to 25000000 Hz.
- R6: The calculator result is N = floor(fin/(2*f)) - 1, where f is the clamped request. This is raised by one when floor(fin/(2*(N+1))) > f.
- R7: A result above 255 is reported as 255. When floor(fin/(2*f)) is 0, the result is 0.
- R8: calc_start is sampled high while the calculator is idle. calc_done then goes low at that edge and goes high with the new calc_div FREQ_W+1 edges later. calc_done and calc_div then hold until the next accepted start.
- R9: calc_start pulses while a calculation is in progress are ignored. They change neither the result nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DIV_W+1 | Bit 8 enable, bits 7:0 divider N |
| calc_start | input | 1 | Start pulse for the calculator |
| calc_in_hz | input | FREQ_W | Input clock frequency in Hz |
| calc_req_hz | input | FREQ_W | Requested card frequency in Hz |
| calc_done | output | 1 | Result valid level |
| calc_div | output | DIV_W | Computed divider value |
| card_clk | output | 1 | Divided card clock |

## Verification
The hardest case to reach from the ports is a divider rewrite that lands in the middle of a running phase. The stimulus waits for an observed rising edge of card_clk and writes the new N on the very next clock edge. The phase lengths measured before and after the following transition then show that the old length was kept for the phase in progress. A second awkward case is a start pulse during the 32-cycle division. The bench injects one with different operands partway through and expects the original result, on the original cycle.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int DIV_W_DEF  = 8;
  localparam int FREQ_W_DEF = 32;
  localparam int F_MIN_DEF  = 200000;
  localparam int F_MAX_DEF  = 25000000;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_DIV  = 2'd1,
    C_FIX  = 2'd2
  } calc_st_e;
endpackage

// File: rtl/cclk_clamp.sv
module cclk_clamp #(
  parameter int FREQ_W = 32,
  parameter int F_MIN  = 200000,
  parameter int F_MAX  = 25000000
) (
  input  logic [FREQ_W-1:0] req_hz,
  output logic [FREQ_W-1:0] lim_hz
);
  localparam logic [FREQ_W-1:0] LO = FREQ_W'(F_MIN);
  localparam logic [FREQ_W-1:0] HI = FREQ_W'(F_MAX);

  always_comb begin
    if (req_hz < LO)      lim_hz = LO;
    else if (req_hz > HI) lim_hz = HI;
    else                  lim_hz = req_hz;
  end
endmodule

// File: rtl/cclk_calc.sv
module cclk_calc
  import cclk_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FREQ_W = 32,
  parameter int F_MIN  = 200000,
  parameter int F_MAX  = 25000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] in_hz,
  input  logic [FREQ_W-1:0] req_hz,
  output logic              done,
  output logic [DIV_W-1:0]  result
);
  localparam int IW = $clog2(FREQ_W);
  localparam logic [FREQ_W:0] SAT = (FREQ_W+1)'((1 << DIV_W) - 1);

  calc_st_e          st;
  logic [IW-1:0]     iter;
  logic [FREQ_W-1:0] quo;
  logic [FREQ_W:0]   rem;
  logic [FREQ_W:0]   dvs;
  logic [FREQ_W-1:0] lim_hz;
  logic [FREQ_W:0]   rem_sh;
  logic [FREQ_W:0]   q_dbl;
  logic [FREQ_W:0]   n_wide;
  logic [DIV_W-1:0]  n_sat;
  logic              bump;
  logic              done_q;
  logic [DIV_W-1:0]  res_q;

  cclk_clamp #(.FREQ_W(FREQ_W), .F_MIN(F_MIN), .F_MAX(F_MAX)) u_clamp (
    .req_hz (req_hz),
    .lim_hz (lim_hz)
  );

  // One restoring step: shift in the next dividend bit.
  assign rem_sh = {rem[FREQ_W-1:0], quo[FREQ_W-1]};

  // Raising the estimate is needed exactly when remainder >= 2*quotient.
  always_comb begin
    q_dbl  = {quo, 1'b0};
    bump   = (rem >= q_dbl);
    n_wide = {1'b0, quo} + (FREQ_W+1)'(bump) - (FREQ_W+1)'(1);
    if (quo == '0)         n_sat = '0;
    else if (n_wide > SAT) n_sat = SAT[DIV_W-1:0];
    else                   n_sat = n_wide[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= C_IDLE;
      iter   <= '0;
      quo    <= '0;
      rem    <= '0;
      dvs    <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      case (st)
        C_IDLE: if (start) begin
          done_q <= 1'b0;
          quo    <= in_hz;
          rem    <= '0;
          dvs    <= {lim_hz, 1'b0};
          iter   <= '0;
          st     <= C_DIV;
        end
        C_DIV: begin
          if (rem_sh >= dvs) begin
            rem <= rem_sh - dvs;
            quo <= {quo[FREQ_W-2:0], 1'b1};
          end else begin
            rem <= rem_sh;
            quo <= {quo[FREQ_W-2:0], 1'b0};
          end
          if (iter == IW'(FREQ_W-1)) st <= C_FIX;
          else                       iter <= iter + 1'b1;
        end
        C_FIX: begin
          res_q  <= n_sat;
          done_q <= 1'b1;
          st     <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign result = res_q;

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    done_q && $past(done_q) |-> $stable(res_q));
  a_r8_not_done_busy: assert property (@(posedge clk) disable iff (rst)
    (st != C_IDLE) |-> !done_q);
  a_r9_divisor_kept: assert property (@(posedge clk) disable iff (rst)
    (st == C_DIV) && ($past(st) == C_DIV) |-> $stable(dvs));
  a_r8_done_from_fix: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(st) == C_FIX);
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DIV_W:0]   cfg_wdata,
  output logic             card_clk
);
  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] cnt;
  logic             clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (cfg_we) begin
      en_q  <= cfg_wdata[DIV_W];
      div_q <= cfg_wdata[DIV_W-1:0];
    end
  end

  // The active divisor is reloaded only on an output transition.
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q   <= 1'b0;
      cnt     <= '0;
      act_div <= '0;
    end else if (!en_q) begin
      clk_q   <= 1'b0;
      cnt     <= '0;
      act_div <= cfg_we ? cfg_wdata[DIV_W-1:0] : div_q;
    end else if (cnt == act_div) begin
      clk_q   <= ~clk_q;
      cnt     <= '0;
      act_div <= div_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign card_clk = clk_q;

  a_r3_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !clk_q);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    en_q |-> cnt <= act_div);
  a_r4_reload_on_edge: assert property (@(posedge clk) disable iff (rst)
    en_q && $past(en_q) && (clk_q == $past(clk_q)) |-> act_div == $past(act_div));
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import cclk_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEF,
  parameter int FREQ_W = FREQ_W_DEF,
  parameter int F_MIN  = F_MIN_DEF,
  parameter int F_MAX  = F_MAX_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DIV_W:0]    cfg_wdata,
  input  logic              calc_start,
  input  logic [FREQ_W-1:0] calc_in_hz,
  input  logic [FREQ_W-1:0] calc_req_hz,
  output logic              calc_done,
  output logic [DIV_W-1:0]  calc_div,
  output logic              card_clk
);
  cclk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .card_clk  (card_clk)
  );

  cclk_calc #(.DIV_W(DIV_W), .FREQ_W(FREQ_W), .F_MIN(F_MIN), .F_MAX(F_MAX)) u_calc (
    .clk    (clk),
    .rst    (rst),
    .start  (calc_start),
    .in_hz  (calc_in_hz),
    .req_hz (calc_req_hz),
    .done   (calc_done),
    .result (calc_div)
  );
endmodule

// File: tb/tb_card_clk_gen.sv
module tb_card_clk_gen;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_wdata = '0;
  logic        calc_start = 1'b0;
  logic [31:0] calc_in_hz = '0;
  logic [31:0] calc_req_hz = '0;
  logic        calc_done;
  logic [7:0]  calc_div;
  logic        card_clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  int    exp_q[$];
  int    due_q[$];
  string tag_q[$];

  card_clk_gen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .calc_start(calc_start), .calc_in_hz(calc_in_hz), .calc_req_hz(calc_req_hz),
    .calc_done(calc_done), .calc_div(calc_div), .card_clk(card_clk)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic int ref_div(longint unsigned fin, longint unsigned freq);
    longint unsigned f, q, est, act;
    f = freq;
    if (f < 200000) f = 200000;
    if (f > 25000000) f = 25000000;
    q = fin / (2 * f);
    if (q == 0) return 0;
    est = q - 1;
    act = fin / (2 * (est + 1));
    if (act > f) est++;
    if (est > 255) est = 255;
    return int'(est);
  endfunction

  // Monitor: compares each result and its arrival cycle against the queue.
  bit prev_done = 0;
  always @(negedge clk) begin
    if (!rst && calc_done && !prev_done) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected done", 1, 0);
      end else begin
        chk({tag_q[0], " value"}, int'(calc_div), exp_q[0]);
        chk("R8 done timing", cyc, due_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
    prev_done <= calc_done;
  end

  task automatic calc_req(longint unsigned fin, longint unsigned freq, string tag, bit poke);
    calc_in_hz  = 32'(fin);
    calc_req_hz = 32'(freq);
    calc_start  = 1'b1;
    @(posedge clk);
    #1 calc_start = 1'b0;
    @(negedge clk);
    chk("R8 done low after start", int'(calc_done), 0);
    exp_q.push_back(ref_div(fin, freq));
    due_q.push_back(cyc + W + 1);
    tag_q.push_back(tag);
    if (poke) begin
      repeat (5) @(negedge clk);
      calc_in_hz  = 32'd50000000;
      calc_req_hz = 32'd1000000;
      calc_start  = 1'b1;
      @(negedge clk);
      calc_start  = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic cfg_write(bit en, int n);
    cfg_we    = 1'b1;
    cfg_wdata = {en, 8'(n)};
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic wait_level(bit v);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (card_clk != v && guard < 2000);
  endtask

  task automatic check_run(int n);
    int t0, r, f, r2;
    cfg_write(1'b1, n);
    t0 = cyc;
    wait_level(1'b1); r = cyc;
    chk("R2 first rise delay", r - t0, n + 1);
    wait_level(1'b0); f = cyc;
    wait_level(1'b1); r2 = cyc;
    chk("R2 high phase", f - r, n + 1);
    chk("R2 low phase", r2 - f, n + 1);
    @(negedge clk);
    cfg_write(1'b0, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R3 low after stop", int'(card_clk), 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int r, f, r2, f2;
    bit seen_high;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 card_clk reset", int'(card_clk), 0);
    chk("R1 done reset", int'(calc_done), 0);
    chk("R1 div reset", int'(calc_div), 0);

    check_run(0);
    check_run(3);
    check_run(5);

    seen_high = 0;
    repeat (40) begin
      @(negedge clk);
      if (card_clk) seen_high = 1;
    end
    chk("R3 stays low", int'(seen_high), 0);

    // Mid-phase rewrite: old N=3 finishes the high phase, N=1 after.
    cfg_write(1'b1, 3);
    wait_level(1'b1); r = cyc;
    cfg_write(1'b1, 1);
    wait_level(1'b0); f = cyc;
    wait_level(1'b1); r2 = cyc;
    wait_level(1'b0); f2 = cyc;
    chk("R4 phase in progress kept", f - r, 4);
    chk("R4 new low phase", r2 - f, 2);
    chk("R4 new high phase", f2 - r2, 2);
    @(negedge clk);
    cfg_write(1'b0, 0);

    calc_req(100000000, 25000000, "R6 exact", 0);
    calc_req(100000000, 20000000, "R6 bumped", 0);
    calc_req(99000000, 1000000, "R6 odd", 0);
    calc_req(100000000, 50000000, "R5 clamp high", 0);
    calc_req(100000000, 100000, "R5 clamp low", 0);
    calc_req(300000000, 400000, "R7 saturate", 0);
    calc_req(10000000, 25000000, "R7 zero quotient", 0);
    calc_req(64'hFFFF_FFFF, 200000, "R7 max input", 0);
    calc_req(48000000, 400000, "R9 start while busy", 1);

    repeat (10) @(negedge clk);
    chk("R8 done held", int'(calc_done), 1);
    chk("R8 result held", int'(calc_div), ref_div(48000000, 400000));

    summary();
  end
endmodule